// File: doc/BRIEF.md
# Four-Detector Coincidence Time-of-Flight Front-End

This block is the digital front-end of one direct time-of-flight pixel fed by four single-photon detectors. Every detector pulse is modelled as a one-cycle event on the fast timing clock. A pulse stays "live" for a programmable number of cycles. A qualified detection occurs when at least K detectors are live at the same time. K, the coincidence depth, runs from 1 to 4. In timing mode a laser start strobe opens a frame and a 12-bit bin counter begins to run. Each bin is one clock cycle, nominally 312.5 ps, so the full scale of 4096 bins covers 1.28 µs. The first qualified detection freezes the counter and its value becomes the timestamp. If no detection comes before the last bin, the block reports a no-hit result carrying the maximum code.

Between laser shots the same start strobe can open a photon-counting interval instead. During that interval every raw detector pulse is summed, with no coincidence filtering, to give a measure of ambient light. Depth and window are live inputs. They may be changed between shots to follow the ambient level.

Results leave through a single valid/ready output. A result is held, unchanged, until the consumer accepts it. While a result is pending the block does not open a new frame. A start strobe that arrives while a result is pending is dropped.

Top module: `spad_coinc_tof`

## Requirements
- R1: A coincidence is flagged in any cycle where the number of live detectors is at least depth_i+1. depth_i is 2 bits, encoding a depth of 1 to 4.
- R2: A pulse on a detector makes it live in the pulse cycle and in the following win_i-1 cycles. win_i=0 behaves as win_i=1, meaning the same cycle only. A new pulse restarts that detector's window.
- R3: In timing mode (count_mode_i=0), start_i is accepted at clock edge E. A first coincidence sampled at edge E+d then yields res_data_o = d-1, with res_kind_o=0 and res_nohit_o=0. Detector pulses present in the start cycle itself are discarded.
- R4: Only the first coincidence of a frame produces a result. Later coincidences in the same frame produce nothing.
- R5: If no coincidence occurs up to and including code 4095, the frame ends with res_nohit_o=1 and res_data_o=4095. A coincidence at code 4095 is still reported as a hit.
- R6: A depth of 1 (depth_i=0) passes any single detector pulse straight through as a coincidence.
- R7: In counting mode (count_mode_i=1), start_i opens an interval of max(count_len_i,1) cycles, starting with the cycle after the start. The result is the total number of raw detector pulses seen in that interval, with res_kind_o=1. The total saturates at 65535.
- R8: Depth and window values are used as presented in each cycle. Changing them between frames changes how the next frame qualifies detections.
- R9: res_valid_o stays high, and res_data_o, res_nohit_o and res_kind_o stay stable, until a cycle with res_ready_i=1. A start_i seen while a result is pending is ignored.
- R10: After reset res_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, one bin per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_i | input | 4 | One-cycle detector pulses |
| start_i | input | 1 | Laser start / interval start strobe |
| count_mode_i | input | 1 | 0 = timing frame, 1 = photon-counting interval |
| depth_i | input | 2 | Coincidence depth minus one |
| win_i | input | 4 | Coincidence window in cycles |
| count_len_i | input | 16 | Counting interval length in cycles |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer accepts result |
| res_data_o | output | 16 | Timestamp or photon count |
| res_nohit_o | output | 1 | Timing frame ended without a coincidence |
| res_kind_o | output | 1 | 0 = timestamp, 1 = count |

## Verification
The bench targets several exact boundaries:
- Window edge: an event that has just expired must not combine with a late partner. A design with an off-by-one window would report an early, wrong timestamp or miss a hit.
- Start cycle: pulses arriving with the strobe must be discarded, or a frame that should report no-hit returns code 0.
- Range end: a hit exactly at the last code, and the no-hit path, must be distinguished, or the flag or the code comes out wrong.
- Counting interval: a zero-length interval, a saturating count and a start strobe during a stalled result are also driven. Each of these would show as a count one interval off, a wrapped total, or a spurious extra result.

// File: rtl/spad_cdt_pkg.sv
package spad_cdt_pkg;
  localparam int unsigned NDET = 4;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_TIME  = 2'd1,
    SEQ_COUNT = 2'd2
  } seq_state_e;

  function automatic logic [2:0] ones4(input logic [NDET-1:0] v);
    logic [2:0] n;
    n = '0;
    for (int i = 0; i < NDET; i++) n = n + {2'b00, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/spad_coinc_filter.sv
module spad_coinc_filter
  import spad_cdt_pkg::*;
#(
  parameter int unsigned WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [NDET-1:0]  det_i,
  input  logic [1:0]       depth_i,
  input  logic [WIN_W-1:0] win_i,
  output logic             hit_o
);
  logic [NDET-1:0] live;
  logic [WIN_W-1:0] reload;

  assign reload = (win_i == '0) ? '0 : win_i - 1'b1;

  for (genvar g = 0; g < NDET; g++) begin : g_lane
    logic [WIN_W-1:0] tmr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             tmr_q <= '0;
      else if (clr_i)         tmr_q <= '0;
      else if (det_i[g])      tmr_q <= reload;
      else if (tmr_q != '0)   tmr_q <= tmr_q - 1'b1;
    end
    assign live[g] = det_i[g] | (tmr_q != '0);
  end

  assign hit_o = ones4(live) > {1'b0, depth_i};

  // R6
  single_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_i == 2'd0 && |det_i) |-> hit_o);
  // R1
  enough_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(det_i) > depth_i) |-> hit_o);
endmodule

// File: rtl/spad_frame_seq.sv
module spad_frame_seq
  import spad_cdt_pkg::*;
#(
  parameter int unsigned TS_W   = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              busy_i,
  input  logic              hit_i,
  input  logic [NDET-1:0]   det_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              clr_o,
  output logic              load_o,
  output logic [DATA_W-1:0] data_o,
  output logic              nohit_o,
  output logic              kind_o
);
  localparam logic [TS_W-1:0] TS_MAX = '1;

  seq_state_e        state_q;
  logic [TS_W-1:0]   tdc_q;
  logic [DATA_W-1:0] acc_q;
  logic [LEN_W-1:0]  rem_q;
  logic [DATA_W:0]   wide;
  logic [DATA_W-1:0] sum;
  logic              go;

  assign go    = start_i && !busy_i && (state_q == SEQ_IDLE);
  assign clr_o = go;
  assign wide  = {1'b0, acc_q} + (DATA_W+1)'(ones4(det_i));
  assign sum   = wide[DATA_W] ? '1 : wide[DATA_W-1:0];

  always_comb begin
    load_o  = 1'b0;
    data_o  = '0;
    nohit_o = 1'b0;
    kind_o  = 1'b0;
    case (state_q)
      SEQ_TIME: begin
        if (hit_i) begin
          load_o = 1'b1;
          data_o = DATA_W'(tdc_q);
        end else if (tdc_q == TS_MAX) begin
          load_o  = 1'b1;
          nohit_o = 1'b1;
          data_o  = DATA_W'(TS_MAX);
        end
      end
      SEQ_COUNT: begin
        if (rem_q == LEN_W'(1)) begin
          load_o = 1'b1;
          kind_o = 1'b1;
          data_o = sum;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      tdc_q   <= '0;
      acc_q   <= '0;
      rem_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (go) begin
          tdc_q   <= '0;
          acc_q   <= '0;
          rem_q   <= (len_i == '0) ? LEN_W'(1) : len_i;
          state_q <= mode_i ? SEQ_COUNT : SEQ_TIME;
        end
        SEQ_TIME: begin
          if (load_o) state_q <= SEQ_IDLE;
          else        tdc_q   <= tdc_q + 1'b1;
        end
        SEQ_COUNT: begin
          if (load_o) state_q <= SEQ_IDLE;
          else begin
            acc_q <= sum;
            rem_q <= rem_q - 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R4
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (state_q == SEQ_IDLE));
  // R9
  pending_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE && busy_i) |=> (state_q == SEQ_IDLE));
endmodule

// File: rtl/spad_result_hold.sv
module spad_result_hold #(
  parameter int unsigned TS_W   = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              nohit_i,
  input  logic              kind_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              nohit_o,
  output logic              kind_o
);
  localparam logic [DATA_W-1:0] TS_TOP = DATA_W'((1 << TS_W) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      nohit_o <= 1'b0;
      kind_o  <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      nohit_o <= nohit_i;
      kind_o  <= kind_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(nohit_o) && $stable(kind_o)));
  // R5
  nohit_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && nohit_o) |-> (data_o == TS_TOP && !kind_o));
endmodule

// File: rtl/spad_coinc_tof.sv
module spad_coinc_tof
  import spad_cdt_pkg::*;
#(
  parameter int unsigned TS_W   = 12,
  parameter int unsigned WIN_W  = 4,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        det_i,
  input  logic              start_i,
  input  logic              count_mode_i,
  input  logic [1:0]        depth_i,
  input  logic [WIN_W-1:0]  win_i,
  input  logic [LEN_W-1:0]  count_len_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [DATA_W-1:0] res_data_o,
  output logic              res_nohit_o,
  output logic              res_kind_o
);
  logic              clr, hit, load, nohit, kind;
  logic [DATA_W-1:0] data;

  spad_coinc_filter #(.WIN_W(WIN_W)) i_filter (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .det_i(det_i),
    .depth_i(depth_i), .win_i(win_i), .hit_o(hit)
  );

  spad_frame_seq #(.TS_W(TS_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(count_mode_i),
    .busy_i(res_valid_o), .hit_i(hit), .det_i(det_i), .len_i(count_len_i),
    .clr_o(clr), .load_o(load), .data_o(data), .nohit_o(nohit), .kind_o(kind)
  );

  spad_result_hold #(.TS_W(TS_W), .DATA_W(DATA_W)) i_hold (
    .clk(clk), .rst_n(rst_n), .load_i(load), .data_i(data), .nohit_i(nohit),
    .kind_i(kind), .ready_i(res_ready_i), .valid_o(res_valid_o),
    .data_o(res_data_o), .nohit_o(res_nohit_o), .kind_o(res_kind_o)
  );
endmodule

// File: tb/test_spad_coinc_tof.sv
module test_spad_coinc_tof;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  det = '0;
  logic        start = 1'b0;
  logic        cmode = 1'b0;
  logic [1:0]  depth = '0;
  logic [3:0]  win = '0;
  logic [15:0] clen = '0;
  logic        ready = 1'b0;
  logic        valid, nohit, kind;
  logic [15:0] data;

  int n_chk = 0;
  int n_fail = 0;

  logic [3:0] ev [256];
  int         late_d = -1;
  logic [3:0] late_v = '0;
  bit         all_ones = 0;

  spad_coinc_tof i_spad_coinc_tof (
    .clk(clk), .rst_n(rst_n), .det_i(det), .start_i(start), .count_mode_i(cmode),
    .depth_i(depth), .win_i(win), .count_len_i(clen), .res_valid_o(valid),
    .res_ready_i(ready), .res_data_o(data), .res_nohit_o(nohit), .res_kind_o(kind)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] evat(input int d);
    logic [3:0] v;
    if (all_ones) return 4'hF;
    v = (d >= 0 && d < 256) ? ev[d] : 4'h0;
    if (d == late_d) v = v | late_v;
    return v;
  endfunction

  function automatic int first_hit(input int k, input int w);
    int weff = (w == 0) ? 1 : w;
    for (int c = 1; c <= 4096; c++) begin
      int cnt = 0;
      for (int i = 0; i < 4; i++) begin
        bit lv = 0;
        for (int a = 0; a < weff; a++) begin
          logic [3:0] v = evat(c - a);
          if (c - a >= 1 && v[i]) lv = 1;
        end
        cnt += int'(lv);
      end
      if (cnt >= k) return c;
    end
    return -1;
  endfunction

  function automatic int exp_count(input int len);
    int n = (len == 0) ? 1 : len;
    int s = 0;
    for (int d = 1; d <= n; d++) s += $countones(evat(d));
    return (s > 65535) ? 65535 : s;
  endfunction

  task automatic clear_ev();
    for (int d = 0; d < 256; d++) ev[d] = 4'h0;
    late_d = -1; late_v = 4'h0; all_ones = 0;
  endtask

  // Runs one frame; k = depth 1..4, w = window code; consume pops the result
  task automatic frame(input bit cm, input int k, input int w, input int len,
                       input logic [3:0] start_det, input bit consume, input string tag);
    bit got = 0;
    int hold;
    logic [15:0] snap;
    @(negedge clk);
    depth = 2'(k - 1); win = 4'(w); cmode = cm; clen = 16'(len);
    start = 1'b1; det = start_det;
    for (int d = 1; d <= 25000 && !got; d++) begin
      @(negedge clk);
      start = 1'b0;
      if (valid) got = 1;
      else det = evat(d);
    end
    det = 4'h0;
    chk(got, {tag, " result produced"}, int'(got), 1);
    if (cm) begin
      int e = exp_count(len);
      chk(data == 16'(e), {tag, " R7 count"}, int'(data), e);
      chk(kind && !nohit, {tag, " R7 kind/nohit"}, int'({kind, nohit}), 2);
    end else begin
      int h = first_hit(k, w);
      int e = (h < 0) ? 4095 : h - 1;
      chk(data == 16'(e), {tag, " R3 timestamp"}, int'(data), e);
      chk(nohit == (h < 0), {tag, " R5 nohit flag"}, int'(nohit), int'(h < 0));
      chk(!kind, {tag, " R3 kind"}, int'(kind), 0);
    end
    if (consume) begin
      snap = data;
      hold = int'($urandom % 4);
      for (int i = 0; i < hold; i++) begin
        @(negedge clk);
        chk(valid && data == snap, {tag, " R9 held"}, int'(data), int'(snap));
      end
      ready = 1'b1;
      @(negedge clk);
      ready = 1'b0;
      chk(!valid, {tag, " R9 popped"}, int'(valid), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clear_ev();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk(!valid, "R10 reset valid", int'(valid), 0);

    // R6 pass-through
    clear_ev(); ev[5] = 4'b0100;
    frame(0, 1, 1, 0, 4'h0, 1, "R6 depth1");
    // R1 R2 window inside
    clear_ev(); ev[10] = 4'b0001; ev[11] = 4'b0010; ev[12] = 4'b1100;
    frame(0, 4, 3, 0, 4'h0, 1, "R2 win3 in");
    // R2 just expired, then late full coincidence
    clear_ev(); ev[10] = 4'b0001; ev[13] = 4'b1110; ev[40] = 4'hF;
    frame(0, 4, 3, 0, 4'h0, 1, "R2 win3 out");
    // R2 window 0 = same cycle
    clear_ev(); ev[7] = 4'b0011; ev[8] = 4'b0100; ev[20] = 4'b0111;
    frame(0, 3, 0, 0, 4'h0, 1, "R2 win0");
    // R3 start-cycle pulses discarded, no later events: nohit
    clear_ev();
    frame(0, 1, 15, 0, 4'hF, 1, "R3 start discard");
    // R5 hit exactly at last code 4095
    clear_ev(); late_d = 4096; late_v = 4'b1000;
    frame(0, 1, 1, 0, 4'h0, 1, "R5 last code");
    // R4 first of several coincidences
    clear_ev(); ev[3] = 4'b0011; ev[9] = 4'hF; ev[30] = 4'hF;
    frame(0, 2, 2, 0, 4'h0, 1, "R4 first only");
    // R8 same pattern, depth changed at runtime
    frame(0, 4, 2, 0, 4'h0, 1, "R8 depth4");
    // R7 counting, zero length, normal, saturating
    clear_ev(); ev[1] = 4'b1011; ev[2] = 4'hF;
    frame(1, 1, 0, 0, 4'h0, 1, "R7 len0");
    clear_ev(); ev[1] = 4'b1011; ev[5] = 4'b0110; ev[30] = 4'hF; ev[31] = 4'h1;
    frame(1, 4, 0, 30, 4'hF, 1, "R7 len30");
    clear_ev(); all_ones = 1;
    frame(1, 1, 0, 20000, 4'h0, 1, "R7 saturate");
    // R9 start while result pending is ignored
    clear_ev(); ev[2] = 4'h1;
    frame(0, 1, 1, 0, 4'h0, 0, "R9 stall");
    @(negedge clk); start = 1'b1; det = 4'hF;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    chk(valid && data == 16'd1, "R9 pending kept", int'(data), 1);
    ready = 1'b1; @(negedge clk); ready = 1'b0; det = 4'h0;
    repeat (10) @(negedge clk);
    chk(!valid, "R9 dropped start", int'(valid), 0);

    // random frames, R1 R2 R3 R4 R8
    for (int f = 0; f < 30; f++) begin
      int span = 10 + int'($urandom % 60);
      clear_ev();
      for (int d = 1; d <= span; d++)
        for (int i = 0; i < 4; i++)
          if ($urandom % 8 == 0) ev[d][i] = 1'b1;
      if ($urandom % 4 == 0)
        frame(1, 1, 0, 1 + int'($urandom % 80), 4'h0, 1, "R7 random");
      else
        frame(0, 1 + int'($urandom % 4), int'($urandom % 16), 0, 4'h0, 1, "R1 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule